// File: doc/BRIEF.md
# Workgroup Dispatch Grid Walker

This block takes a kernel launch descriptor made of a three-axis grid extent and a three-axis workgroup extent. From these it works out how many workgroups lie along each axis, rounding up so that partial workgroups at the grid edge count as whole ones, and how many lie in the whole grid. It then hands workgroups out one at a time to a scheduler over a valid/ready handshake.

For each workgroup it hands out, the block presents a three-axis workgroup coordinate and a flat index that counts across the whole grid. The coordinate advances like an odometer. An axis wraps when its advanced coordinate, multiplied by that axis's workgroup extent, reaches the grid extent. It does not wrap on a fixed modulus.

After the last workgroup the block raises a dispatch-complete flag and stops offering work. Separately, it counts the pulses from the execution side that report a workgroup has retired. It signals that all work is done once every counted workgroup has retired and dispatch has completed. Loading a new descriptor discards all of this state.

Top module: `wg_walker`

## Requirements
- R1: After a load, each per-axis count equals the ceiling of the grid extent divided by the workgroup extent for that axis.
- R2: The total count equals the product of the three per-axis counts, and exactly that many handshakes are accepted before dispatch completes.
- R3: `busy` rises in the cycle after `load` and stays high until the counts are valid. `disp_valid` is low whenever `busy` is high.
- R4: A `load` resets the coordinate, the flat index, the complete flag and the retired count to zero. It also restarts the count calculation.
- R5: Each accepted handshake (`disp_valid` and `disp_ready` both high) advances `id_x` and `flat_id` by one. Without a handshake, the coordinate and the index hold.
- R6: When the advanced x coordinate times `wg_x` is greater than or equal to `grid_x`, x returns to 0 and y advances. The same test on y returns y to 0 and advances z. As a result, the coordinates are offered in x-fastest order.
- R7: When the test on z also trips, `disp_done` is set and stays set until the next load. `disp_valid` is then low, and the coordinate reads x=0, y=0, z=`cnt_z`.
- R8: `fin_count` advances by one for every cycle in which `wg_finished` is high. This holds whether or not a dispatch is taking place, and also while `busy` is high.
- R9: `all_done` is high exactly when `disp_done` is set and `fin_count` equals `cnt_total`.
- R10: After reset, `busy`, `disp_valid`, `disp_done` and `all_done` are low, and all counts and coordinates are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| load | input | 1 | Latch a new descriptor and start again |
| grid_x | input | GW | Grid extent, x axis (nonzero) |
| grid_y | input | GW | Grid extent, y axis (nonzero) |
| grid_z | input | GW | Grid extent, z axis (nonzero) |
| wg_x | input | GW | Workgroup extent, x axis (nonzero) |
| wg_y | input | GW | Workgroup extent, y axis (nonzero) |
| wg_z | input | GW | Workgroup extent, z axis (nonzero) |
| busy | output | 1 | Counts are being computed |
| cnt_x | output | GW | Workgroups along x |
| cnt_y | output | GW | Workgroups along y |
| cnt_z | output | GW | Workgroups along z |
| cnt_total | output | 3*GW | Workgroups in the grid |
| disp_valid | output | 1 | A workgroup is offered |
| disp_ready | input | 1 | Scheduler takes the offered workgroup |
| id_x | output | GW | Offered workgroup coordinate, x |
| id_y | output | GW | Offered workgroup coordinate, y |
| id_z | output | GW | Offered workgroup coordinate, z |
| flat_id | output | 3*GW | Offered workgroup flat index |
| disp_done | output | 1 | Every workgroup has been handed out |
| wg_finished | input | 1 | One workgroup retired (one pulse per workgroup) |
| fin_count | output | 3*GW | Retired workgroups since load |
| all_done | output | 1 | Dispatch complete and all workgroups retired |

## Verification
The assertions assume that every descriptor loaded has nonzero grid and workgroup extents. They also assume that the execution side never reports more retirements than workgroups handed out, so `fin_count` cannot wrap. The stimulus loads only nonzero extents below 2^GW. It pulses `wg_finished` no more times than the total count of the current descriptor. It raises `disp_ready` only for single handshakes, some of them after a deliberate stall. The bounds property on the coordinate relies on the counts having been produced by the divider for the same descriptor, and that is true only while `busy` is low.

// File: rtl/wg_walker.sv
module wg_walker #(
  parameter int GW = 16,
  localparam int TW = 3 * GW,
  localparam int BW = $clog2(GW)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [GW-1:0] grid_x,
  input  logic [GW-1:0] grid_y,
  input  logic [GW-1:0] grid_z,
  input  logic [GW-1:0] wg_x,
  input  logic [GW-1:0] wg_y,
  input  logic [GW-1:0] wg_z,
  output logic          busy,
  output logic [GW-1:0] cnt_x,
  output logic [GW-1:0] cnt_y,
  output logic [GW-1:0] cnt_z,
  output logic [TW-1:0] cnt_total,
  output logic          disp_valid,
  input  logic          disp_ready,
  output logic [GW-1:0] id_x,
  output logic [GW-1:0] id_y,
  output logic [GW-1:0] id_z,
  output logic [TW-1:0] flat_id,
  output logic          disp_done,
  input  logic          wg_finished,
  output logic [TW-1:0] fin_count,
  output logic          all_done
);

  typedef enum logic [1:0] {S_IDLE, S_DIV, S_MUL, S_RUN} state_t;

  state_t        st;
  logic [GW-1:0] gx, gy, gz, sx, sy, sz;
  logic [GW-1:0] px, py, pz;
  logic [GW-1:0] cx, cy, cz;
  logic [GW-1:0] ix, iy, iz;
  logic [TW-1:0] tot, fid, fin;
  logic          done;
  logic [1:0]    ax;
  logic [BW-1:0] bitn;
  logic [GW-1:0] quo;
  logic [GW:0]   rem;

  logic [GW-1:0] dsor, gnext;
  always_comb begin
    case (ax)
      2'd0:    begin dsor = sx; gnext = gy; end
      2'd1:    begin dsor = sy; gnext = gz; end
      default: begin dsor = sz; gnext = gz; end
    endcase
  end

  wire [GW:0]   rsh = {rem[GW-1:0], quo[GW-1]};
  wire          ge  = rsh >= {1'b0, dsor};
  wire [GW:0]   rnx = ge ? rsh - {1'b0, dsor} : rsh;
  wire [GW-1:0] qnx = {quo[GW-2:0], ge};
  wire [GW-1:0] cq  = qnx + 1'b1;

  wire [GW:0] nx = {1'b0, px} + {1'b0, sx};
  wire [GW:0] ny = {1'b0, py} + {1'b0, sy};
  wire [GW:0] nz = {1'b0, pz} + {1'b0, sz};
  wire trip_x = nx >= {1'b0, gx};
  wire trip_y = ny >= {1'b0, gy};
  wire trip_z = nz >= {1'b0, gz};

  wire fire = disp_valid && disp_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE;
      {gx, gy, gz, sx, sy, sz} <= '0;
      {px, py, pz, cx, cy, cz, ix, iy, iz} <= '0;
      tot <= '0; fid <= '0; fin <= '0; done <= 1'b0;
      ax <= '0; bitn <= '0; quo <= '0; rem <= '0;
    end else if (load) begin
      st <= S_DIV;
      gx <= grid_x; gy <= grid_y; gz <= grid_z;
      sx <= wg_x;   sy <= wg_y;   sz <= wg_z;
      {px, py, pz, cx, cy, cz, ix, iy, iz} <= '0;
      tot <= '0; fid <= '0; fin <= '0; done <= 1'b0;
      ax <= '0; bitn <= '0; rem <= '0;
      quo <= grid_x - 1'b1;
    end else begin
      if (wg_finished) fin <= fin + 1'b1;
      case (st)
        S_DIV: begin
          rem  <= rnx;
          quo  <= qnx;
          bitn <= bitn + 1'b1;
          if (bitn == BW'(GW - 1)) begin
            bitn <= '0;
            rem  <= '0;
            case (ax)
              2'd0:    cx <= cq;
              2'd1:    cy <= cq;
              default: cz <= cq;
            endcase
            if (ax == 2'd2) st <= S_MUL;
            else begin
              ax  <= ax + 1'b1;
              quo <= gnext - 1'b1;
            end
          end
        end
        S_MUL: begin
          tot <= TW'(cx) * TW'(cy) * TW'(cz);
          st  <= S_RUN;
        end
        S_RUN: begin
          if (fire) begin
            fid <= fid + 1'b1;
            if (!trip_x) begin
              ix <= ix + 1'b1;
              px <= nx[GW-1:0];
            end else begin
              ix <= '0; px <= '0;
              if (!trip_y) begin
                iy <= iy + 1'b1;
                py <= ny[GW-1:0];
              end else begin
                iy <= '0; py <= '0;
                iz <= iz + 1'b1;
                pz <= nz[GW-1:0];
                if (trip_z) done <= 1'b1;
              end
            end
          end
        end
        default: ;
      endcase
    end
  end

  assign busy       = (st == S_DIV) || (st == S_MUL);
  assign disp_valid = (st == S_RUN) && !done;
  assign disp_done  = done;
  assign all_done   = done && (fin == tot);
  assign cnt_x = cx;
  assign cnt_y = cy;
  assign cnt_z = cz;
  assign cnt_total = tot;
  assign id_x = ix;
  assign id_y = iy;
  assign id_z = iz;
  assign flat_id   = fid;
  assign fin_count = fin;

endmodule

// File: rtl/wg_walker_chk.sv
module wg_walker_chk #(
  parameter int GW = 16,
  localparam int TW = 3 * GW
) (
  input logic          clk,
  input logic          rst_n,
  input logic          load,
  input logic          busy,
  input logic [GW-1:0] cnt_x,
  input logic [GW-1:0] cnt_y,
  input logic [GW-1:0] cnt_z,
  input logic          disp_valid,
  input logic          disp_ready,
  input logic [GW-1:0] id_x,
  input logic [GW-1:0] id_y,
  input logic [GW-1:0] id_z,
  input logic [TW-1:0] flat_id,
  input logic          disp_done,
  input logic          wg_finished,
  input logic [TW-1:0] fin_count,
  input logic          all_done
);

  a_r3_no_offer_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !disp_valid);

  a_r7_no_offer_after_done: assert property (@(posedge clk) disable iff (!rst_n)
    disp_done |-> !disp_valid);

  a_r7_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (disp_done && !load) |=> disp_done);

  a_r4_load_clears: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (busy && flat_id == '0 && !disp_done && fin_count == '0 &&
              id_x == '0 && id_y == '0 && id_z == '0));

  a_r5_index_steps: assert property (@(posedge clk) disable iff (!rst_n)
    (disp_valid && disp_ready && !load) |=> flat_id == $past(flat_id) + 1'b1);

  a_r5_hold_without_handshake: assert property (@(posedge clk) disable iff (!rst_n)
    (!(disp_valid && disp_ready) && !load) |=>
      ($stable(flat_id) && $stable(id_x) && $stable(id_y) && $stable(id_z)));

  a_r6_coord_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    disp_valid |-> (id_x < cnt_x && id_y < cnt_y && id_z < cnt_z));

  a_r8_retire_counts: assert property (@(posedge clk) disable iff (!rst_n)
    (wg_finished && !load) |=> fin_count == $past(fin_count) + 1'b1);

  a_r9_all_done_needs_dispatch: assert property (@(posedge clk) disable iff (!rst_n)
    all_done |-> disp_done);

endmodule

bind wg_walker wg_walker_chk #(.GW(GW)) u_chk (
  .clk(clk), .rst_n(rst_n), .load(load), .busy(busy),
  .cnt_x(cnt_x), .cnt_y(cnt_y), .cnt_z(cnt_z),
  .disp_valid(disp_valid), .disp_ready(disp_ready),
  .id_x(id_x), .id_y(id_y), .id_z(id_z), .flat_id(flat_id),
  .disp_done(disp_done), .wg_finished(wg_finished),
  .fin_count(fin_count), .all_done(all_done)
);

// File: tb/sim_wg_walker.sv
module sim_wg_walker;
  localparam int GW = 16;
  localparam int TW = 3 * GW;
  localparam int PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0, load = 1'b0, disp_ready = 1'b0, wg_finished = 1'b0;
  logic [GW-1:0] grid_x = '0, grid_y = '0, grid_z = '0, wg_x = '0, wg_y = '0, wg_z = '0;
  logic busy, disp_valid, disp_done, all_done;
  logic [GW-1:0] cnt_x, cnt_y, cnt_z, id_x, id_y, id_z;
  logic [TW-1:0] cnt_total, flat_id, fin_count;

  int checks = 0, errors = 0;
  bit finished = 0;

  always #(PERIOD/2) clk = ~clk;

  wg_walker #(.GW(GW)) u0 (
    .clk(clk), .rst_n(rst_n), .load(load),
    .grid_x(grid_x), .grid_y(grid_y), .grid_z(grid_z),
    .wg_x(wg_x), .wg_y(wg_y), .wg_z(wg_z),
    .busy(busy), .cnt_x(cnt_x), .cnt_y(cnt_y), .cnt_z(cnt_z), .cnt_total(cnt_total),
    .disp_valid(disp_valid), .disp_ready(disp_ready),
    .id_x(id_x), .id_y(id_y), .id_z(id_z), .flat_id(flat_id),
    .disp_done(disp_done), .wg_finished(wg_finished),
    .fin_count(fin_count), .all_done(all_done)
  );

  task automatic chk(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic longint ceil_div(input longint g, input longint w);
    return (g + w - 1) / w;
  endfunction

  task automatic do_load(input int gx, gy, gz, wx, wy, wz);
    @(negedge clk);
    grid_x = GW'(gx); grid_y = GW'(gy); grid_z = GW'(gz);
    wg_x = GW'(wx); wg_y = GW'(wy); wg_z = GW'(wz);
    load = 1'b1;
    @(negedge clk);
    load = 1'b0;
    chk("R3 busy after load", busy, 1);
    chk("R3 no offer while busy", disp_valid, 0);
    chk("R4 flat index cleared", flat_id, 0);
    chk("R4 done cleared", disp_done, 0);
    chk("R4 coord cleared", {id_z, id_y, id_x}, 0);
  endtask

  task automatic wait_counts();
    for (int i = 0; i < 200 && busy; i++) @(negedge clk);
    chk("R3 busy falls", busy, 0);
  endtask

  task automatic check_counts(input int gx, gy, gz, wx, wy, wz);
    longint ex, ey, ez;
    ex = ceil_div(gx, wx); ey = ceil_div(gy, wy); ez = ceil_div(gz, wz);
    chk("R1 cnt_x", cnt_x, ex);
    chk("R1 cnt_y", cnt_y, ey);
    chk("R1 cnt_z", cnt_z, ez);
    chk("R2 cnt_total", cnt_total, ex * ey * ez);
  endtask

  task automatic pulse_fin(input int n);
    for (int i = 0; i < n; i++) begin
      wg_finished = 1'b1;
      @(negedge clk);
      wg_finished = 1'b0;
    end
  endtask

  task automatic walk(input int gx, gy, gz, wx, wy, wz, input bit stall);
    longint ex, ey, ez, g;
    ex = ceil_div(gx, wx); ey = ceil_div(gy, wy); ez = ceil_div(gz, wz);
    g = 0;
    for (longint z = 0; z < ez; z++)
      for (longint y = 0; y < ey; y++)
        for (longint x = 0; x < ex; x++) begin
          chk("R2 offer present", disp_valid, 1);
          chk("R6 id_x order", id_x, x);
          chk("R6 id_y order", id_y, y);
          chk("R6 id_z order", id_z, z);
          chk("R5 flat index", flat_id, g);
          if (stall && g[0]) begin
            @(negedge clk);
            chk("R5 hold without ready", {id_z, id_y, id_x}, {z[15:0], y[15:0], x[15:0]});
            chk("R5 flat hold", flat_id, g);
          end
          disp_ready = 1'b1;
          @(negedge clk);
          disp_ready = 1'b0;
          g++;
        end
    chk("R7 done set", disp_done, 1);
    chk("R7 valid dropped", disp_valid, 0);
    chk("R7 final coord x", id_x, 0);
    chk("R7 final coord y", id_y, 0);
    chk("R7 final coord z", id_z, ez);
    chk("R2 handshakes equal total", flat_id, ex * ey * ez);
    disp_ready = 1'b1;
    @(negedge clk);
    disp_ready = 1'b0;
    chk("R7 no step after done", flat_id, ex * ey * ez);
    chk("R7 done sticky", disp_done, 1);
  endtask

  task automatic full_case(input int gx, gy, gz, wx, wy, wz, input bit stall);
    longint t;
    do_load(gx, gy, gz, wx, wy, wz);
    wait_counts();
    check_counts(gx, gy, gz, wx, wy, wz);
    walk(gx, gy, gz, wx, wy, wz, stall);
    t = ceil_div(gx, wx) * ceil_div(gy, wy) * ceil_div(gz, wz);
    pulse_fin(int'(t) - 1);
    chk("R8 retired count", fin_count, t - 1);
    chk("R9 all_done low one short", all_done, 0);
    pulse_fin(1);
    chk("R9 all_done high", all_done, 1);
  endtask

  task automatic test_reset();
    chk("R10 busy", busy, 0);
    chk("R10 valid", disp_valid, 0);
    chk("R10 done", disp_done, 0);
    chk("R10 all_done", all_done, 0);
    chk("R10 counts", {cnt_x, cnt_y, cnt_z}, 0);
    chk("R10 total", cnt_total, 0);
    chk("R10 coord", {id_z, id_y, id_x}, 0);
  endtask

  task automatic test_reload();
    do_load(10, 3, 2, 4, 2, 1);
    pulse_fin(2);
    wait_counts();
    chk("R8 retire counted while busy", fin_count, 2);
    for (int i = 0; i < 4; i++) begin
      disp_ready = 1'b1;
      @(negedge clk);
      disp_ready = 1'b0;
    end
    chk("R6 mid walk x", id_x, 1);
    chk("R6 mid walk y", id_y, 1);
    wg_finished = 1'b1;
    disp_ready = 1'b1;
    @(negedge clk);
    wg_finished = 1'b0;
    disp_ready = 1'b0;
    chk("R8 retire alongside dispatch", fin_count, 3);
    chk("R5 step alongside retire", flat_id, 5);
    do_load(8, 4, 1, 4, 4, 1);
    chk("R4 retired cleared", fin_count, 0);
    wait_counts();
    check_counts(8, 4, 1, 4, 4, 1);
    walk(8, 4, 1, 4, 4, 1, 1'b0);
  endtask

  task automatic test_wide();
    do_load(65535, 300, 2, 1, 7, 2);
    wait_counts();
    check_counts(65535, 300, 2, 1, 7, 2);
    chk("R3 offer after counts", disp_valid, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    test_reset();
    full_case(10, 3, 2, 4, 2, 1, 1'b1);
    full_case(8, 4, 1, 4, 4, 1, 1'b0);
    full_case(3, 1, 1, 1, 1, 1, 1'b1);
    full_case(5, 7, 3, 16, 16, 16, 1'b0);
    full_case(7, 5, 3, 3, 2, 2, 1'b1);
    test_reload();
    test_wide();
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(PERIOD * 150000);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule